// File: doc/BRIEF.md
# ARINC 429 Return-to-Zero Receive Channel

This block is one receive channel for an ARINC 429 link whose three-level line has already been split into two digital return-to-zero lines: one line pulses for each logic 1 and the other pulses for each logic 0. The channel synchronises both lines and takes a bit at every rising edge. It builds a 32-bit word from those bits, and a gap counter driven by an ARINC-rate tick finds the end of that word. The counter restarts at each falling edge of the combined line activity.

When the word ends, the channel checks it. It must have exactly 32 bits and no collision. It must pass the parity check when that check is enabled. Its label (bits 7:0, first received) must be allowed in a 256-entry one-bit acceptance memory when label checking is on. A word that passes goes into a read buffer that the host sees as two 16-bit halves. If the buffer is still occupied, the word waits in the shift register. The host releases the buffer by reading the low half, and a waiting word then moves in. A word that fails only on parity raises a sticky flag in the control readback. A loopback input pair can replace the external lines for self-test.

Top module: `a429_rx_channel`

## Requirements
- R1: After reset, buf_full, irq_rx, ctrl_rd, word_hi and word_lo are all zero.
- R2: A rising edge on rx_one gives a 1 bit and a rising edge on rx_zero gives a 0 bit. The first bit received lands in bit 0 of the word and the last in bit 31. word_hi shows bits 31:16 and word_lo shows bits 15:0.
- R3: The gap counter advances on each arinc_tick while a word is in progress and restarts at each falling edge of the combined lines. When it reaches the value written through gap_wr, the word is evaluated.
- R4: A word with fewer or more than 32 bits, or one during which both lines were high together, is discarded.
- R5: Control bit 10 enables the parity check and bit 11 selects odd (1) or even (0). The parity is taken over all 32 bits, bit 31 included.
- R6: Control bit 13 enables label checking. The label is word bits 7:0, and the word is accepted only if the memory entry at that label is 1.
- R7: A label memory write through lbl_wr changes the memory only while control bit 12 is 1. Otherwise it has no effect.
- R8: An accepted word loads the buffer when the buffer is empty and sets buf_full. A one-cycle lo_rd pulse frees the buffer.
- R9: A valid word that ends while the buffer is full is held. It enters the buffer two cycles after the releasing lo_rd. If a newer word starts first, the held word is lost.
- R10: A word that fails only on parity (with the check enabled) sets ctrl_rd bit 7. A control write with bit 7 = 0 clears it, and a write with bit 7 = 1 leaves it as it was.
- R11: With control bit 14 set, the channel receives from lb_one/lb_zero and ignores rx_one/rx_zero.
- R12: With control bit 15 clear, no bits are taken, no word is accepted and irq_rx is low. irq_rx is buf_full while bit 15 is set. ctrl_rd returns the written value with bit 7 replaced by the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arinc_tick | input | 1 | One-cycle pulse at the ARINC timing rate |
| rx_one | input | 1 | External line that pulses for logic 1 |
| rx_zero | input | 1 | External line that pulses for logic 0 |
| lb_one | input | 1 | Loopback line for logic 1 |
| lb_zero | input | 1 | Loopback line for logic 0 |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_wdata | input | 16 | Control write value |
| ctrl_rd | output | 16 | Control readback, bit 7 = parity fault flag |
| gap_wr | input | 1 | Gap register write strobe |
| gap_wdata | input | 8 | Gap length in ticks |
| lbl_wr | input | 1 | Label memory write strobe |
| lbl_addr | input | 8 | Label memory write address |
| lbl_wbit | input | 1 | Label memory write value |
| lo_rd | input | 1 | Read of the low half; releases the buffer |
| word_hi | output | 16 | Buffered word bits 31:16 |
| word_lo | output | 16 | Buffered word bits 15:0 |
| buf_full | output | 1 | Buffer holds an unread word |
| irq_rx | output | 1 | Receive interrupt request |

## Verification
Two things can land on the same clock edge: the end-of-word evaluation of a new valid word, and the host's release of the buffer through lo_rd. The bench fills the buffer and sends a second word. It then sweeps the lo_rd pulse over every cycle of the gap tail, so that the release falls before the evaluation, on the same edge, and after it. In every case the buffer must end up holding the second word with buf_full set. A behavioural model follows this across all offsets and is compared against the outputs on every quiet clock.

// File: rtl/a429_rx_pkg.sv
package a429_rx_pkg;

    typedef struct packed {
        logic en;        // channel in service
        logic loop;      // receive from loopback lines
        logic lbl_chk;   // label acceptance check
        logic lbl_prog;  // label memory programming allowed
        logic odd;       // odd parity when 1, even when 0
        logic par_en;    // parity check enabled
    } rx_ctrl_t;

    localparam int CTRL_W     = 16;
    localparam int FLAG_BIT   = 7;

    function automatic rx_ctrl_t decode_ctrl(input logic [CTRL_W-1:0] raw);
        rx_ctrl_t c;
        c.en       = raw[15];
        c.loop     = raw[14];
        c.lbl_chk  = raw[13];
        c.lbl_prog = raw[12];
        c.odd      = raw[11];
        c.par_en   = raw[10];
        return c;
    endfunction

endpackage

// File: rtl/a429_rx_front.sv
module a429_rx_front #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_one,
    input  logic ext_zero,
    input  logic lp_one,
    input  logic lp_zero,
    input  logic sel_loop,
    output logic rise_one,
    output logic rise_zero,
    output logic both_hi,
    output logic act_fall
);
    localparam int TOP = SYNC_STAGES - 1;

    typedef struct packed {
        logic [SYNC_STAGES-1:0] one_sh;
        logic [SYNC_STAGES-1:0] zero_sh;
        logic                   one_p;
        logic                   zero_p;
    } front_t;

    front_t st_q, st_d;
    logic   src_one, src_zero, s_one, s_zero;

    always_comb begin
        src_one  = sel_loop ? lp_one  : ext_one;
        src_zero = sel_loop ? lp_zero : ext_zero;
        s_one    = st_q.one_sh[TOP];
        s_zero   = st_q.zero_sh[TOP];

        st_d         = st_q;
        st_d.one_sh  = {st_q.one_sh[SYNC_STAGES-2:0], src_one};
        st_d.zero_sh = {st_q.zero_sh[SYNC_STAGES-2:0], src_zero};
        st_d.one_p   = s_one;
        st_d.zero_p  = s_zero;

        rise_one  = s_one  & ~st_q.one_p;
        rise_zero = s_zero & ~st_q.zero_p;
        both_hi   = s_one & s_zero;
        act_fall  = (st_q.one_p | st_q.zero_p) & ~(s_one | s_zero);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R2
    edge_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise_one |=> !rise_one);

endmodule

// File: rtl/a429_rx_gap.sv
module a429_rx_gap #(
    parameter int GAP_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             clr,
    input  logic             run,
    input  logic [GAP_W-1:0] gap_val,
    output logic             eom
);
    typedef struct packed {
        logic [GAP_W-1:0] cnt;
    } gap_t;

    gap_t             st_q, st_d;
    logic [GAP_W-1:0] cnt_nxt;

    always_comb begin
        st_d    = st_q;
        eom     = 1'b0;
        cnt_nxt = st_q.cnt + 1'b1;
        if (clr) begin
            st_d.cnt = '0;
        end else if (run && tick) begin
            if (cnt_nxt == gap_val) eom = 1'b1;
            else                    st_d.cnt = cnt_nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R3
    gap_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (st_q.cnt == '0));

endmodule

// File: rtl/a429_rx_lblmem.sv
module a429_rx_lblmem #(
    parameter int LBL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             prog_en,
    input  logic [LBL_W-1:0] wr_addr,
    input  logic             wr_bit,
    input  logic [LBL_W-1:0] rd_addr,
    output logic             rd_bit
);
    localparam int DEPTH = 1 << LBL_W;

    logic [DEPTH-1:0] mem_q, mem_d;

    always_comb begin
        mem_d = mem_q;
        if (wr_en && prog_en) mem_d[wr_addr] = wr_bit;
        rd_bit = mem_q[rd_addr];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mem_q <= '0;
        else        mem_q <= mem_d;
    end

    // R7
    lbl_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !prog_en) |=> $stable(mem_q));

endmodule

// File: rtl/a429_rx_channel.sv
module a429_rx_channel
    import a429_rx_pkg::*;
#(
    parameter int WORD_W      = 32,
    parameter int GAP_W       = 8,
    parameter int LBL_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                arinc_tick,
    input  logic                rx_one,
    input  logic                rx_zero,
    input  logic                lb_one,
    input  logic                lb_zero,
    input  logic                ctrl_wr,
    input  logic [15:0]         ctrl_wdata,
    output logic [15:0]         ctrl_rd,
    input  logic                gap_wr,
    input  logic [GAP_W-1:0]    gap_wdata,
    input  logic                lbl_wr,
    input  logic [LBL_W-1:0]    lbl_addr,
    input  logic                lbl_wbit,
    input  logic                lo_rd,
    output logic [WORD_W/2-1:0] word_hi,
    output logic [WORD_W/2-1:0] word_lo,
    output logic                buf_full,
    output logic                irq_rx
);
    localparam int HALF  = WORD_W / 2;
    localparam int CNT_W = $clog2(WORD_W) + 1;

    typedef struct packed {
        logic [CTRL_W-1:0] ctrl;
        logic              flag;
        logic [GAP_W-1:0]  gap;
        logic              in_word;
        logic [CNT_W-1:0]  bitcnt;
        logic              bad;
        logic [WORD_W-1:0] sh;
        logic              pend;
        logic [WORD_W-1:0] bufw;
        logic              full;
    } chan_t;

    chan_t    st_q, st_d;
    rx_ctrl_t cfg;
    logic     rise_one, rise_zero, both_hi, act_fall;
    logic     eom, gap_clr, gap_run, lbl_hit;
    logic     bit_evt, collide, starting;
    logic     count_ok, par_ok, lbl_ok;

    assign cfg = decode_ctrl(st_q.ctrl);

    a429_rx_front #(.SYNC_STAGES(SYNC_STAGES)) front_i (
        .clk(clk), .rst_n(rst_n),
        .ext_one(rx_one), .ext_zero(rx_zero),
        .lp_one(lb_one), .lp_zero(lb_zero),
        .sel_loop(cfg.loop),
        .rise_one(rise_one), .rise_zero(rise_zero),
        .both_hi(both_hi), .act_fall(act_fall)
    );

    a429_rx_gap #(.GAP_W(GAP_W)) gap_i (
        .clk(clk), .rst_n(rst_n),
        .tick(arinc_tick), .clr(gap_clr), .run(gap_run),
        .gap_val(st_q.gap), .eom(eom)
    );

    a429_rx_lblmem #(.LBL_W(LBL_W)) lbl_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en(lbl_wr), .prog_en(cfg.lbl_prog),
        .wr_addr(lbl_addr), .wr_bit(lbl_wbit),
        .rd_addr(st_q.sh[LBL_W-1:0]), .rd_bit(lbl_hit)
    );

    always_comb begin
        bit_evt  = cfg.en & (rise_one | rise_zero);
        collide  = (rise_one & rise_zero) | both_hi;
        gap_clr  = act_fall | (bit_evt & ~st_q.in_word);
        gap_run  = st_q.in_word & cfg.en;
        count_ok = (st_q.bitcnt == CNT_W'(WORD_W)) & ~st_q.bad;
        par_ok   = ~cfg.par_en | ((^st_q.sh) == cfg.odd);
        lbl_ok   = ~cfg.lbl_chk | lbl_hit;
        starting = ~st_q.in_word | eom;

        st_d = st_q;

        // host side: control and gap registers
        if (ctrl_wr) begin
            st_d.ctrl           = ctrl_wdata;
            st_d.ctrl[FLAG_BIT] = 1'b0;
            st_d.flag           = st_q.flag & ctrl_wdata[FLAG_BIT];
        end
        if (gap_wr) st_d.gap = gap_wdata;

        // buffer release
        if (lo_rd) st_d.full = 1'b0;

        // held word moves into a freed buffer
        if (st_q.pend && !st_q.full) begin
            st_d.bufw = st_q.sh;
            st_d.full = 1'b1;
            st_d.pend = 1'b0;
        end

        // end-of-word evaluation
        if (eom) begin
            st_d.in_word = 1'b0;
            if (count_ok && lbl_ok) begin
                if (par_ok) begin
                    if (!st_q.full) begin
                        st_d.bufw = st_q.sh;
                        st_d.full = 1'b1;
                    end else begin
                        st_d.pend = 1'b1;
                    end
                end else begin
                    st_d.flag = 1'b1;
                end
            end
        end

        // bit capture
        if (bit_evt) begin
            st_d.pend    = 1'b0;
            st_d.in_word = 1'b1;
            if (starting) begin
                st_d.bitcnt = CNT_W'(1);
                st_d.sh     = {rise_one, {(WORD_W-1){1'b0}}};
                st_d.bad    = collide;
            end else begin
                if (st_q.bitcnt != '1) st_d.bitcnt = st_q.bitcnt + 1'b1;
                st_d.sh  = {rise_one, st_q.sh[WORD_W-1:1]};
                st_d.bad = st_q.bad | collide;
            end
        end else if (st_q.in_word && both_hi) begin
            st_d.bad = 1'b1;
        end

        if (!cfg.en) st_d.in_word = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign word_hi  = st_q.bufw[WORD_W-1:HALF];
    assign word_lo  = st_q.bufw[HALF-1:0];
    assign buf_full = st_q.full;
    assign irq_rx   = st_q.full & cfg.en;
    always_comb begin
        ctrl_rd           = st_q.ctrl;
        ctrl_rd[FLAG_BIT] = st_q.flag;
    end

    // R8
    buf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.full && !lo_rd) |=> (st_q.full && $stable(st_q.bufw)));

    // R9
    held_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pend && !st_q.full) |=> (st_q.full && !st_q.pend));

    // R10
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.flag && !(ctrl_wr && !ctrl_wdata[FLAG_BIT])) |=> st_q.flag);

    // R3
    single_eom_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eom |=> !eom);

endmodule

// File: tb/a429_rx_channel_tb_top.sv
module a429_rx_channel_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        arinc_tick = 1'b0;
    logic        rx_one = 1'b0, rx_zero = 1'b0, lb_one = 1'b0, lb_zero = 1'b0;
    logic        ctrl_wr = 1'b0;
    logic [15:0] ctrl_wdata = '0;
    logic [15:0] ctrl_rd;
    logic        gap_wr = 1'b0;
    logic [7:0]  gap_wdata = '0;
    logic        lbl_wr = 1'b0;
    logic [7:0]  lbl_addr = '0;
    logic        lbl_wbit = 1'b0;
    logic        lo_rd = 1'b0;
    logic [15:0] word_hi, word_lo;
    logic        buf_full, irq_rx;

    always #2.5 clk = ~clk;

    a429_rx_channel dut_i (
        .clk(clk), .rst_n(rst_n), .arinc_tick(arinc_tick),
        .rx_one(rx_one), .rx_zero(rx_zero), .lb_one(lb_one), .lb_zero(lb_zero),
        .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata), .ctrl_rd(ctrl_rd),
        .gap_wr(gap_wr), .gap_wdata(gap_wdata),
        .lbl_wr(lbl_wr), .lbl_addr(lbl_addr), .lbl_wbit(lbl_wbit),
        .lo_rd(lo_rd), .word_hi(word_hi), .word_lo(word_lo),
        .buf_full(buf_full), .irq_rx(irq_rx)
    );

    always @(negedge clk) arinc_tick <= rst_n ? ~arinc_tick : 1'b0;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // behavioural model
    logic [31:0] m_buf = '0;
    bit          m_full = 0;
    bit          m_pend = 0;
    logic [31:0] m_pendw = '0;
    bit          m_flag = 0;
    logic [15:0] m_ctrl = '0;
    bit          m_lbl [256];
    bit          mon_on = 0;
    bit          mon_bad = 0;
    bit          force_ext = 0;

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic check_state(input string tag);
        chk(tag, "buf_full", {31'b0, buf_full}, {31'b0, m_full});
        chk(tag, "irq_rx", {31'b0, irq_rx}, {31'b0, m_full & m_ctrl[15]});
        chk(tag, "flag", {31'b0, ctrl_rd[7]}, {31'b0, m_flag});
        if (m_full) chk(tag, "word", {word_hi, word_lo}, m_buf);
    endtask

    // per-clock comparison in quiet windows
    always @(negedge clk) begin
        if (mon_on && !mon_bad && rst_n) begin
            if (buf_full !== m_full || irq_rx !== (m_full & m_ctrl[15]) ||
                ctrl_rd[7] !== m_flag ||
                (m_full && {word_hi, word_lo} !== m_buf)) begin
                mon_bad = 1;
                errors++;
                $display("FAIL R8 monitor actual %b/%h expected %b/%h",
                         buf_full, {word_hi, word_lo}, m_full, m_buf);
            end
        end
    end

    task automatic ctrl_write(input logic [15:0] v);
        @(negedge clk); ctrl_wr = 1; ctrl_wdata = v;
        @(negedge clk); ctrl_wr = 0;
        m_ctrl = {v[15:8], 1'b0, v[6:0]};
        if (!v[7]) m_flag = 0;
        @(negedge clk);
    endtask

    task automatic lbl_write(input logic [7:0] a, input bit b);
        @(negedge clk); lbl_wr = 1; lbl_addr = a; lbl_wbit = b;
        @(negedge clk); lbl_wr = 0;
        if (m_ctrl[12]) m_lbl[a] = b;
    endtask

    task automatic read_lo();
        mon_on = 0;
        @(negedge clk); lo_rd = 1;
        @(negedge clk); lo_rd = 0;
        m_full = 0;
        if (m_pend) begin m_full = 1; m_buf = m_pendw; m_pend = 0; end
        repeat (3) @(negedge clk);
        mon_on = 1;
    endtask

    task automatic set_lines(input bit one, input bit zero);
        if (m_ctrl[14] && !force_ext) begin lb_one = one; lb_zero = zero; end
        else begin rx_one = one; rx_zero = zero; end
    endtask

    // sends nbits of w (bit i from w[i%32]); clash_at: bit index with both lines high
    task automatic send(input logic [31:0] w, input int nbits, input int clash_at,
                        input int rd_at);
        bit heard, ok;
        mon_on = 0;
        for (int i = 0; i < nbits; i++) begin
            @(negedge clk);
            if (i == clash_at) set_lines(1, 1);
            else               set_lines(w[i % 32], !w[i % 32]);
            repeat (2) @(negedge clk);
            @(negedge clk); set_lines(0, 0);
            repeat (2) @(negedge clk);
        end
        for (int t = 0; t < 50; t++) begin
            @(negedge clk);
            lo_rd = (t == rd_at);
        end
        lo_rd = 0;
        repeat (3) @(negedge clk);
        heard = m_ctrl[15] && (nbits > 0) && !(force_ext && m_ctrl[14]);
        if (heard) begin
            m_pend = 0;
            if (nbits == 32 && clash_at < 0 && (!m_ctrl[13] || m_lbl[w[7:0]])) begin
                ok = !m_ctrl[10] || ((^w) == m_ctrl[11]);
                if (ok) begin
                    if (!m_full) begin m_full = 1; m_buf = w; end
                    else begin m_pend = 1; m_pendw = w; end
                end else begin
                    m_flag = 1;
                end
            end
        end
        mon_on = 1;
    endtask

    function automatic logic [31:0] with_par(input logic [30:0] body, input bit odd);
        return {(^body) ^ odd, body};
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] wa, wb, wc, wev, wod;
        wa = 32'hA5C3_1E6B;
        wb = 32'h1234_5678;
        wc = 32'h0F0F_99C4;

        repeat (5) @(negedge clk);
        // R1 reset state
        chk("R1", "buf_full", {31'b0, buf_full}, 32'd0);
        chk("R1", "irq_rx", {31'b0, irq_rx}, 32'd0);
        chk("R1", "ctrl_rd", {16'b0, ctrl_rd}, 32'd0);
        chk("R1", "word", {word_hi, word_lo}, 32'd0);
        rst_n = 1;
        repeat (3) @(negedge clk);

        @(negedge clk); gap_wr = 1; gap_wdata = 8'd10;
        @(negedge clk); gap_wr = 0;
        ctrl_write(16'h8000);
        chk("R12", "ctrl_rd", {16'b0, ctrl_rd}, 32'h0000_8000);
        mon_on = 1;

        // R2 / R3 basic capture
        send(wa, 32, -1, -1);
        chk("R2", "word_hi", {16'b0, word_hi}, {16'b0, wa[31:16]});
        chk("R2", "word_lo", {16'b0, word_lo}, {16'b0, wa[15:0]});
        check_state("R3");
        read_lo();
        check_state("R8");

        // R4 bit-count and collision faults
        send(wb, 31, -1, -1); check_state("R4");
        send(wb, 33, -1, -1); check_state("R4");
        send(wb, 32, 5, -1);  check_state("R4");
        send(wb, 32, -1, -1); check_state("R3");
        read_lo();

        // R5 / R10 parity
        ctrl_write(16'h8C00);
        wev = with_par(31'h2A5B_3C7D, 1'b0);
        wod = with_par(31'h2A5B_3C7D, 1'b1);
        send(wev, 32, -1, -1); check_state("R10");
        chk("R5", "rejected", {31'b0, buf_full}, 32'd0);
        send(wod, 32, -1, -1); check_state("R5");
        read_lo();
        ctrl_write(16'h8C80);
        chk("R10", "flag kept", {31'b0, ctrl_rd[7]}, 32'd1);
        ctrl_write(16'h8C00);
        chk("R10", "flag cleared", {31'b0, ctrl_rd[7]}, 32'd0);
        ctrl_write(16'h8400);
        send(wev, 32, -1, -1); check_state("R5");
        read_lo();
        send(wod, 32, -1, -1); check_state("R5");

        // R6 / R7 label memory
        ctrl_write(16'hA000);
        wc[7:0] = 8'h3C;
        send(wc, 32, -1, -1); check_state("R6");
        lbl_write(8'h3C, 1'b1);
        send(wc, 32, -1, -1); check_state("R7");
        chk("R7", "locked write", {31'b0, buf_full}, 32'd0);
        ctrl_write(16'hB000);
        lbl_write(8'h3C, 1'b1);
        ctrl_write(16'hA000);
        send(wc, 32, -1, -1); check_state("R6");
        read_lo();
        wc[7:0] = 8'h3D;
        send(wc, 32, -1, -1); check_state("R6");

        // R9 held word and overwrite
        ctrl_write(16'h8000);
        send(wa, 32, -1, -1);
        send(wb, 32, -1, -1); check_state("R9");
        read_lo();            check_state("R9");
        read_lo();
        send(wa, 32, -1, -1);
        send(wb, 32, -1, -1);
        send(wc, 32, -1, -1);
        read_lo();
        chk("R9", "overwrite", {word_hi, word_lo}, wc);
        read_lo();

        // R8 / R9 release colliding with end of word
        send(wa, 32, -1, -1);
        for (int off = 0; off < 45; off++) begin
            send(wb, 32, -1, off);
            m_full = 1; m_buf = wb; m_pend = 0;
            check_state("R9");
            read_lo();
            send(wa, 32, -1, -1);
        end
        read_lo();

        // R11 loopback
        ctrl_write(16'hC000);
        force_ext = 1;
        send(wb, 32, -1, -1); check_state("R11");
        force_ext = 0;
        send(wb, 32, -1, -1); check_state("R11");
        read_lo();

        // R12 disabled channel
        ctrl_write(16'h8000);
        send(wa, 32, -1, -1);
        ctrl_write(16'h0000);
        check_state("R12");
        chk("R12", "irq low", {31'b0, irq_rx}, 32'd0);
        send(wc, 32, -1, -1); check_state("R12");

        repeat (5) @(negedge clk);
        finish_run();
    end

endmodule